// File: doc/BRIEF.md
# Sparse Early-Reflection FIR Engine

This block produces the early-reflection part of an audio reverberator. It works as a multi-tap FIR filter with no multiplier. Each incoming 16-bit sample goes into a circular history of 2,500 entries. A controller then walks a preloaded list holding only the non-zero taps. Each tap names how far back in the history to look, a right-shift amount and a sign. The selected history words pass through a two-stage pipeline. The first stage is the buffer read register. The second stage shifts, applies the sign and adds into a 24-bit accumulator. When the last tap has drained, the sum is saturated to 16 bits and presented for one cycle.

Coefficients that are zero are never stored and so cost no cycles. A frame with N active taps takes N+2 clocks from input to output. At 44.1 kHz this leaves plenty of headroom even at the full 64-tap list. The tap list is written through a simple word-write port and is taken to be stable while a sample is in flight. Generating the pseudo-random tap pattern and deserializing the audio link are done elsewhere.

Top module: `er_fir_engine`

## Requirements
- R1: After reset the engine zeroes every history location, one per clock, and holds `in_ready` low until that sweep is finished. Until real samples overwrite them, all history words read as 0.
- R2: `in_ready` is high only while the engine is idle. A sample is taken on a rising clock edge where both `in_valid` and `in_ready` are high. An `in_valid` seen while `in_ready` is low changes no history word and no output.
- R3: Each accepted sample produces `out_data` = sat16( sum over tap index k < `tap_count` of term_k ). term_k uses the history word written `offset_k` samples before the current one, so offset 0 is the sample just accepted.
- R4: A term is the history word sign-extended, arithmetically shifted right by the tap's 4-bit shift (rounding toward minus infinity), and then negated if the tap's sign bit is 1.
- R5: Terms are summed in 24 bits. The result is clamped to the range -32768 to 32767 on output.
- R6: The history is circular with 2,500 words. Writing wraps from position 2,499 to position 0, and an offset of up to 2,499 reaches across the wrap point.
- R7: `out_valid` pulses for exactly one clock, N+2 rising edges after the accepting edge, where N is the clamped `tap_count`. `in_ready` returns high on that same edge.
- R8: With `tap_count` = 0 the engine still answers each sample, with `out_data` = 0 after 2 clocks.
- R9: `out_data` keeps its value between `out_valid` pulses.
- R10: A clock edge with `tap_wr_en` high stores offset, shift and sign into tap entry `tap_wr_addr`. Entries at or above `tap_count` take no part in the sum. Values of `tap_count` above 64 act as 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Engine idle and able to take a sample |
| out_valid | output | 1 | One-clock pulse: `out_data` holds a new result |
| out_data | output | 16 | Signed saturated filter output |
| tap_wr_en | input | 1 | Write strobe for the tap list |
| tap_wr_addr | input | 6 | Tap entry index to write |
| tap_wr_offset | input | 12 | Delay in samples, 0 to 2,499 |
| tap_wr_shift | input | 4 | Right-shift amount of the tap |
| tap_wr_neg | input | 1 | 1 = subtract the term |
| tap_count | input | 7 | Number of active tap entries, 0 to 64 |

## Verification
The hardest case to reach from the ports is a tap that reads across the wrap of the circular history. It needs more than 2,500 accepted samples before the write position passes the end and the oldest-offset tap straddles it. The stimulus drives a 2,600-sample stream through taps at offsets 0, 1,300 and 2,499. It compares every output against a model history kept in the bench, so the wrap is crossed by both the write pointer and the long-delay read. Input offered while the engine is busy is exercised as well. The bench holds `in_valid` high with a different value through a whole frame, then reads the history back through a one-sample-delay tap.

// File: rtl/er_pkg.sv
// Shared definitions for the early-reflection FIR engine.
// Assumes: nothing beyond IEEE 1800-2017.
package er_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR = 3'd0,
        ST_IDLE  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } er_state_e;

endpackage

// File: rtl/er_sample_ring.sv
// Circular sample history with a zeroing sweep after reset.
// Writes the accepted sample one slot past the newest, and reads
// (newest - offset) mod DEPTH into a registered output (pipeline stage 1).
// Assumes: offsets are below DEPTH; no read and write in the same cycle.
module er_sample_ring #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2500,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);
    localparam logic [AW:0]   DEPTH_X = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     head;
    logic [AW-1:0]     clr_idx;
    logic [AW-1:0]     next_head;
    logic [AW:0]       rd_sum;
    logic [AW-1:0]     rd_addr;
    logic              mem_we;
    logic [AW-1:0]     mem_wa;
    logic [DATA_W-1:0] mem_wd;

    // Next write slot, wrapping at the end of the history.
    always_comb next_head = (head == LAST) ? '0 : head + 1'b1;

    // Read address: newest slot minus the tap offset, modulo DEPTH.
    always_comb begin
        rd_sum  = {1'b0, head} + DEPTH_X - {1'b0, rd_off};
        rd_addr = (rd_sum >= DEPTH_X) ? AW'(rd_sum - DEPTH_X) : AW'(rd_sum);
    end

    // Write port mux: zeroing sweep first, then accepted samples.
    always_comb begin
        mem_we = !ready || wr_en;
        mem_wa = ready ? next_head : clr_idx;
        mem_wd = ready ? wr_data : '0;
    end

    // Storage array; written without reset.
    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= mem_wd;
    end

    // Stage-1 pipeline register holding the fetched history word.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

    // Zeroing sweep counter and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_idx <= '0;
            ready   <= 1'b0;
        end else if (!ready) begin
            clr_idx <= clr_idx + 1'b1;
            if (clr_idx == LAST) ready <= 1'b1;
        end
    end

    // Newest-sample pointer; starts at the last slot so the first write lands at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                head <= LAST;
        else if (ready && wr_en)   head <= next_head;
    end

endmodule

// File: rtl/er_tap_table.sv
// Register file of non-zero taps: offset, shift and sign per entry.
// Written one entry per clock; read combinationally by tap index.
// Assumes: not rewritten while a frame is in flight.
module er_tap_table #(
    parameter int TAPS  = 64,
    parameter int OFF_W = 12,
    parameter int SH_W  = 4,
    parameter int IDX_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [SH_W-1:0]  wr_sh,
    input  logic             wr_neg,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [OFF_W-1:0] rd_off,
    output logic [SH_W-1:0]  rd_sh,
    output logic             rd_neg
);
    logic [OFF_W-1:0] off_q [TAPS];
    logic [SH_W-1:0]  sh_q  [TAPS];
    logic             neg_q [TAPS];

    // Per-entry storage, cleared on reset.
    generate
        for (genvar g = 0; g < TAPS; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    off_q[g] <= '0;
                    sh_q[g]  <= '0;
                    neg_q[g] <= 1'b0;
                end else if (wr_en && wr_addr == IDX_W'(g)) begin
                    off_q[g] <= wr_off;
                    sh_q[g]  <= wr_sh;
                    neg_q[g] <= wr_neg;
                end
            end
        end
    endgenerate

    // Read selection for the tap being issued.
    always_comb begin
        rd_off = off_q[rd_idx];
        rd_sh  = sh_q[rd_idx];
        rd_neg = neg_q[rd_idx];
    end

endmodule

// File: rtl/er_ctrl.sv
// Sequencer: waits for the history sweep, accepts a sample when idle,
// issues one tap per clock, drains the pipeline and emits the result.
// Frame length is N+2 clocks from the accepting edge to the emit edge.
// Assumes: tap_count stable during a frame.
module er_ctrl #(
    parameter int TAPS  = 64,
    parameter int IDX_W = $clog2(TAPS),
    parameter int CNT_W = $clog2(TAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_ready,
    input  logic             in_valid,
    input  logic [CNT_W-1:0] tap_count,
    output logic             in_ready,
    output logic             accept,
    output logic             issue,
    output logic [IDX_W-1:0] tap_idx,
    output logic             emit
);
    import er_pkg::*;

    localparam logic [CNT_W-1:0] TAPS_C = CNT_W'(TAPS);

    er_state_e        state;
    logic [CNT_W-1:0] n_eff;
    logic             last_tap;

    // Clamp the active tap count to the table size.
    always_comb n_eff = (tap_count > TAPS_C) ? TAPS_C : tap_count;

    // Last tap of the frame is being issued this cycle.
    always_comb last_tap = ({1'b0, tap_idx} == (n_eff - 1'b1));

    // Decoded strobes of the current state.
    always_comb begin
        in_ready = (state == ST_IDLE);
        accept   = in_ready && in_valid;
        issue    = (state == ST_RUN);
        emit     = (state == ST_DONE);
    end

    // State register and tap index walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            tap_idx <= '0;
        end else begin
            case (state)
                ST_CLEAR: if (ring_ready) state <= ST_IDLE;
                ST_IDLE: begin
                    tap_idx <= '0;
                    if (in_valid) state <= (n_eff == '0) ? ST_DRAIN : ST_RUN;
                end
                ST_RUN: begin
                    tap_idx <= tap_idx + 1'b1;
                    if (last_tap) state <= ST_DRAIN;
                end
                ST_DRAIN: state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_CLEAR;
            endcase
        end
    end

endmodule

// File: rtl/er_accum.sv
// Pipeline stage 2: shift the fetched word, apply the sign, add into the
// accumulator, and on emit saturate the sum into the output register.
// Assumes: ACC_W > DATA_W; the fetched word is valid one clock after issue.
module er_accum #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24,
    parameter int SH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [SH_W-1:0]   sh_in,
    input  logic              neg_in,
    input  logic [DATA_W-1:0] sample,
    input  logic              acc_clr,
    input  logic              emit,
    output logic [ACC_W-1:0]  acc_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SMIN = -SMAX - 1;

    logic                     p1_valid;
    logic [SH_W-1:0]          p1_sh;
    logic                     p1_neg;
    logic signed [ACC_W-1:0]  ext;
    logic signed [ACC_W-1:0]  shifted;
    logic signed [ACC_W-1:0]  term;
    logic signed [ACC_W-1:0]  acc_q;

    // Stage-1 control registers travelling beside the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_valid <= 1'b0;
            p1_sh    <= '0;
            p1_neg   <= 1'b0;
        end else begin
            p1_valid <= issue;
            p1_sh    <= sh_in;
            p1_neg   <= neg_in;
        end
    end

    // Shifter and sign stage feeding the adder.
    always_comb begin
        ext     = {{(ACC_W - DATA_W){sample[DATA_W-1]}}, sample};
        shifted = ext >>> p1_sh;
        term    = p1_neg ? -shifted : shifted;
    end

    // Accumulator: cleared on accept, adds one term per valid stage-2 cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (acc_clr)  acc_q <= '0;
        else if (p1_valid) acc_q <= acc_q + term;
    end

    // Saturating output register and one-clock valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                if (acc_q > SMAX)      out_data <= SMAX[DATA_W-1:0];
                else if (acc_q < SMIN) out_data <= SMIN[DATA_W-1:0];
                else                   out_data <= acc_q[DATA_W-1:0];
            end
        end
    end

    always_comb acc_val = acc_q;

endmodule

// File: rtl/er_fir_engine.sv
// Top of the sparse early-reflection FIR engine: history ring, tap list,
// sequencer and shift-add accumulator.
// Assumes: tap offsets below DEPTH, tap list stable during a frame.
module er_fir_engine #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24,
    parameter int DEPTH  = 2500,
    parameter int TAPS   = 64,
    parameter int SH_W   = 4,
    parameter int OFF_W  = $clog2(DEPTH),
    parameter int IDX_W  = $clog2(TAPS),
    parameter int CNT_W  = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              tap_wr_en,
    input  logic [IDX_W-1:0]  tap_wr_addr,
    input  logic [OFF_W-1:0]  tap_wr_offset,
    input  logic [SH_W-1:0]   tap_wr_shift,
    input  logic              tap_wr_neg,
    input  logic [CNT_W-1:0]  tap_count
);
    logic              ring_ready;
    logic              accept;
    logic              issue;
    logic              emit;
    logic [IDX_W-1:0]  tap_idx;
    logic [OFF_W-1:0]  cur_off;
    logic [SH_W-1:0]   cur_sh;
    logic              cur_neg;
    logic [DATA_W-1:0] fetched;
    logic [ACC_W-1:0]  acc_val;

    er_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_ready (ring_ready),
        .in_valid   (in_valid),
        .tap_count  (tap_count),
        .in_ready   (in_ready),
        .accept     (accept),
        .issue      (issue),
        .tap_idx    (tap_idx),
        .emit       (emit)
    );

    er_tap_table #(.TAPS(TAPS), .OFF_W(OFF_W), .SH_W(SH_W), .IDX_W(IDX_W)) u_taps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tap_wr_en),
        .wr_addr (tap_wr_addr),
        .wr_off  (tap_wr_offset),
        .wr_sh   (tap_wr_shift),
        .wr_neg  (tap_wr_neg),
        .rd_idx  (tap_idx),
        .rd_off  (cur_off),
        .rd_sh   (cur_sh),
        .rd_neg  (cur_neg)
    );

    er_sample_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(OFF_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_data (in_data),
        .rd_en   (issue),
        .rd_off  (cur_off),
        .rd_data (fetched),
        .ready   (ring_ready)
    );

    er_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .sh_in     (cur_sh),
        .neg_in    (cur_neg),
        .sample    (fetched),
        .acc_clr   (accept),
        .emit      (emit),
        .acc_val   (acc_val),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/er_fir_engine_chk.sv
// Temporal checks on the engine's handshake, output pulse and saturation.
// Attached to every er_fir_engine instance by the bind below.
module er_fir_engine_chk #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              ring_ready,
    input logic [ACC_W-1:0]  acc_val
);
    localparam logic signed [ACC_W-1:0]  AMAX = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0]  AMIN = -AMAX - 1;
    localparam logic [DATA_W-1:0]        OMAX = AMAX[DATA_W-1:0];
    localparam logic [DATA_W-1:0]        OMIN = AMIN[DATA_W-1:0];

    // R1: no sample is taken during the zeroing sweep.
    a_r1_no_ready_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_ready |-> !in_ready);

    // R2: an accepted sample makes the engine busy on the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R7: the result strobe lasts one clock.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7: the engine is ready again when the result appears.
    a_r7_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

    // R9: output data holds between pulses.
    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R5: an over-range sum clamps to the positive limit.
    a_r5_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($signed($past(acc_val)) > AMAX)) |-> (out_data == OMAX));

    // R5: an under-range sum clamps to the negative limit.
    a_r5_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($signed($past(acc_val)) < AMIN)) |-> (out_data == OMIN));

endmodule

bind er_fir_engine er_fir_engine_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .ring_ready (ring_ready),
    .acc_val    (acc_val)
);

// File: tb/er_fir_engine_test.sv
// Directed bench: one task per scenario, each checking against a model
// history kept here.
module er_fir_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2500;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        tap_wr_en = 1'b0;
    logic [5:0]  tap_wr_addr = '0;
    logic [11:0] tap_wr_offset = '0;
    logic [3:0]  tap_wr_shift = '0;
    logic        tap_wr_neg = 1'b0;
    logic [6:0]  tap_count = '0;

    int tests  = 0;
    int fails  = 0;
    int cycles = 0;

    int hist [DEPTH];
    int head = DEPTH - 1;
    int m_off [64];
    int m_sh  [64];
    int m_neg [64];
    int m_cnt = 0;

    er_fir_engine uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .tap_wr_en     (tap_wr_en),
        .tap_wr_addr   (tap_wr_addr),
        .tap_wr_offset (tap_wr_offset),
        .tap_wr_shift  (tap_wr_shift),
        .tap_wr_neg    (tap_wr_neg),
        .tap_count     (tap_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                tests++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_out();
        int sum = 0;
        int n   = (m_cnt > 64) ? 64 : m_cnt;
        for (int k = 0; k < n; k++) begin
            int idx = head - m_off[k];
            int v;
            if (idx < 0) idx += DEPTH;
            v = hist[idx] >>> m_sh[k];
            sum += (m_neg[k] != 0) ? -v : v;
        end
        if (sum > 32767)  sum = 32767;
        if (sum < -32768) sum = -32768;
        return sum;
    endfunction

    task automatic set_tap(input int idx, input int off, input int sh, input int neg);
        @(negedge clk);
        tap_wr_en     = 1'b1;
        tap_wr_addr   = 6'(idx);
        tap_wr_offset = 12'(off);
        tap_wr_shift  = 4'(sh);
        tap_wr_neg    = neg[0];
        @(negedge clk);
        tap_wr_en = 1'b0;
        m_off[idx] = off;
        m_sh[idx]  = sh;
        m_neg[idx] = neg;
    endtask

    task automatic set_count(input int n);
        @(negedge clk);
        tap_count = 7'(n);
        m_cnt = n;
    endtask

    function automatic void model_push(input int s);
        head = (head == DEPTH - 1) ? 0 : head + 1;
        hist[head] = s;
    endfunction

    // Sends one sample, returns the output and the edges to out_valid.
    task automatic send(input int s, output int res, output int lat);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(s);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        model_push(s);
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!out_valid && lat < 200);
        res = int'($signed(out_data));
    endtask

    task automatic t_reset();
        int wait_cyc = 0;
        @(negedge clk);
        check(in_ready == 1'b0, "R1 ready low after reset", int'(in_ready), 0);
        check(out_valid == 1'b0 && out_data == 16'h0, "R9 output idle at reset", int'(out_data), 0);
        while (!in_ready && wait_cyc < 3000) begin
            @(negedge clk);
            wait_cyc++;
        end
        check(wait_cyc >= DEPTH - 1 && in_ready, "R1 sweep length", wait_cyc, DEPTH);
    endtask

    task automatic t_identity();
        int r, l;
        set_tap(0, 0, 0, 0);
        set_count(1);
        send(1234, r, l);
        check(r == 1234, "R3 single tap identity", r, 1234);
        check(l == 3, "R7 latency one tap", l, 3);
        send(-777, r, l);
        check(r == -777, "R3 negative identity", r, -777);
    endtask

    task automatic t_history_zero();
        int r, l;
        set_tap(0, 0, 0, 0);
        set_tap(1, 2400, 0, 0);
        set_count(2);
        send(100, r, l);
        check(r == 100, "R1 unwritten history reads zero", r, 100);
    endtask

    task automatic t_shift_sign();
        int r, l, e;
        set_tap(0, 0, 1, 0);
        set_tap(1, 0, 3, 1);
        set_tap(2, 1, 15, 0);
        set_tap(3, 1, 4, 1);
        set_count(4);
        send(-1001, r, l);
        send(-3, r, l);
        e = model_out();
        check(r == e, "R4 shift and sign terms", r, e);
        check(l == 6, "R7 latency four taps", l, 6);
        send(5000, r, l);
        e = model_out();
        check(r == e, "R4 positive shifts", r, e);
    endtask

    task automatic t_delays();
        int r, l, e;
        set_tap(0, 0, 0, 0);
        set_tap(1, 3, 1, 0);
        set_tap(2, 7, 2, 1);
        set_count(3);
        for (int i = 0; i < 10; i++) begin
            send(i * 311 - 1500, r, l);
            e = model_out();
            check(r == e, "R3 delayed taps", r, e);
        end
    endtask

    task automatic t_saturate();
        int r, l;
        for (int k = 0; k < 4; k++) set_tap(k, 0, 0, 0);
        set_count(4);
        send(30000, r, l);
        check(r == 32767, "R5 clamp high", r, 32767);
        send(-30000, r, l);
        check(r == -32768, "R5 clamp low", r, -32768);
        send(8191, r, l);
        check(r == 32764, "R5 in range no clamp", r, 32764);
    endtask

    task automatic t_zero_taps();
        int r, l;
        set_count(0);
        send(9999, r, l);
        check(r == 0, "R8 empty tap list output", r, 0);
        check(l == 2, "R8 empty tap list latency", l, 2);
    endtask

    task automatic t_count_limit();
        int r, l, e;
        for (int k = 0; k < 64; k++) set_tap(k, k, 6, k % 2);
        set_count(100);
        send(20000, r, l);
        e = model_out();
        check(r == e, "R10 count above table clamps", r, e);
        check(l == 66, "R10 clamped latency", l, 66);
        set_count(2);
        send(4096, r, l);
        e = model_out();
        check(r == e, "R10 entries past count unused", r, e);
    endtask

    task automatic t_ignore_busy();
        int lat = 0;
        int busy_bad = 0;
        int r, l, e;
        set_tap(0, 0, 0, 0);
        set_tap(1, 1, 0, 0);
        set_count(2);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'd500;
        @(posedge clk);
        @(negedge clk);
        model_push(500);
        in_data = 16'd7000;
        do begin
            if (!out_valid && in_ready) busy_bad++;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!out_valid && lat < 200);
        in_valid = 1'b0;
        check(busy_bad == 0, "R2 ready low while busy", busy_bad, 0);
        e = model_out();
        check(int'($signed(out_data)) == e, "R2 frame result", int'($signed(out_data)), e);
        send(20, r, l);
        check(r == 520, "R2 busy input ignored", r, 520);
    endtask

    task automatic t_hold();
        int r, l;
        logic [15:0] snap;
        send(321, r, l);
        snap = out_data;
        repeat (5) @(negedge clk);
        check(out_data == snap && !out_valid, "R9 output holds", int'(out_data), int'(snap));
    endtask

    task automatic t_wrap();
        int r, l, e;
        int bad = 0;
        int first_bad = 0;
        int first_exp = 0;
        set_tap(0, 0, 0, 0);
        set_tap(1, 1300, 1, 1);
        set_tap(2, DEPTH - 1, 0, 0);
        set_count(3);
        for (int i = 0; i < 2600; i++) begin
            send(((i * 37) % 2000) - 1000, r, l);
            e = model_out();
            if (r != e && bad == 0) begin
                first_bad = r;
                first_exp = e;
            end
            if (r != e) bad++;
        end
        check(bad == 0, "R6 wrap stream first mismatch", first_bad, first_exp);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_history_zero();
        t_identity();
        t_shift_sign();
        t_delays();
        t_saturate();
        t_zero_taps();
        t_count_limit();
        t_ignore_busy();
        t_hold();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule